// File: doc/BRIEF.md
# DRAM Read-Capture Tap Calibrator

This engine searches a fixed list of eleven read-capture delay codes for one that works on a DRAM interface. For each candidate it drives the code onto four byte-lane tap buses and waits a programmable settling time. It then writes four known halfwords through a request/acknowledge memory port and reads the containing line back in one access. The candidate passes when the halfword at byte address 4 comes back intact.

A start pulse begins the search. The engine first scans upward from the lowest table entry until one passes; that entry is the left edge. It then scans downward from the highest entry until one passes; that entry is the right edge. It settles on the entry halfway between the two edges and drives it onto all four lanes. If nothing passes on the upward scan, the engine flags a failure and drives code zero. A narrow-bus indicator stays high for the whole search, so the controller runs the test traffic in 16-bit mode.

Top module: `tapcal_top`

## Requirements
- R1: The candidate codes are visited only from this fixed table, indexed 0 to 10: 0x40, 0x41, 0x10, 0x12, 0x13, 0x15, 0x1A, 0x1C, 0x1F, 0x2F, 0x3F. The current candidate is driven on lane 0 (bits 7:0) of `tap_lanes` while it is being tested.
- R2: For every candidate the port carries exactly five accesses, in this order. First come writes of 0x00A5, 0x00B6, 0x00C7 and 0x00D8 to byte addresses 0, 2, 4 and 6. Then comes one read at address 0.
- R3: The read line holds halfword n at bits 16n+15:16n. A candidate passes only when bits 47:32 (byte address 4) equal 0x00C7. The other halfwords are ignored.
- R4: The upward scan starts at index 0 and stops at the first passing index (the left edge).
- R5: The downward scan starts at index 10 and stops at the first passing index (the right edge).
- R6: On completion, `done` rises and all four 8-bit lanes carry the table entry at index (left+right)>>1, rounded down. `done` and the lanes then hold until the next start.
- R7: After each new candidate is applied (start, or the acknowledge of a read that leads to another candidate), the first write request rises exactly `settle_cycles`+1 clock edges later.
- R8: A request holds its address, direction and data until acknowledged. Only one access is outstanding at a time.
- R9: If no index passes on the upward scan, `fail` and `done` rise after all eleven candidates, and every lane drives 0x00.
- R10: A start while the search runs is ignored. A start while idle or finished restarts the search and clears `done` and `fail`.
- R11: `half_mode` is high exactly while a search is in progress.
- R12: The downward scan never goes below the left edge. If the left edge fails when revisited, the right edge is taken to equal the left edge.
- R13: After reset `done`, `fail`, `mem_req` and `half_mode` are low and all lanes drive 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration when idle or finished |
| settle_cycles | input | SETTLE_W | Extra wait cycles after each tap change |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = line read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 16 | Halfword to write |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| mem_rdata | input | 64 | Read line, valid with the read acknowledge |
| tap_lanes | output | 8*LANES | Tap code for each byte lane |
| half_mode | output | 1 | Requests 16-bit interface mode during the search |
| done | output | 1 | Calibration finished |
| fail | output | 1 | No candidate passed |

## Verification
A start pulse and a memory acknowledge can fall in the same cycle. The engine must then complete the access and ignore the start. The bench's memory model raises a stray start together with its fifth acknowledge, which is the read acknowledge of the first candidate. The run is judged against the same expected edges, read count, settle gaps and access order as an undisturbed run. Any restart would show up as a longer access sequence, a mismatched read count or a wrong final code.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;
    localparam int NUM_TAPS = 11;
    localparam int IDX_W    = 4;
    localparam int TAP_W    = 8;
    localparam int HW_W     = 16;
    localparam int LINE_W   = 64;
    localparam int CHK_HW   = 2;                 // halfword slot of byte address 4
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TAPS - 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETTLE, ST_WRITE, ST_READ, ST_DONE
    } st_e;

    function automatic logic [HW_W-1:0] pattern_word(input logic [1:0] k);
        return 16'h00A5 + 16'h0011 * HW_W'(k);
    endfunction
endpackage

// File: rtl/tapcal_table.sv
module tapcal_table
    import tapcal_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [TAP_W-1:0] code
);
    always_comb begin
        unique case (idx)
            4'd0:    code = 8'h40;
            4'd1:    code = 8'h41;
            4'd2:    code = 8'h10;
            4'd3:    code = 8'h12;
            4'd4:    code = 8'h13;
            4'd5:    code = 8'h15;
            4'd6:    code = 8'h1A;
            4'd7:    code = 8'h1C;
            4'd8:    code = 8'h1F;
            4'd9:    code = 8'h2F;
            4'd10:   code = 8'h3F;
            default: code = 8'h00;
        endcase
    end
endmodule

// File: rtl/tapcal_settle.sv
module tapcal_settle #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SETTLE_W-1:0] load_val,
    output logic                expired
);
    logic [SETTLE_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R7: a freshly loaded nonzero count is not expired on the next cycle
    a_r7_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/tapcal_ctrl.sv
module tapcal_ctrl
    import tapcal_pkg::*;
#(
    parameter int SETTLE_W = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                settle_expired,
    input  logic                mem_ack,
    input  logic [LINE_W-1:0]   mem_rdata,
    output logic                settle_load,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [HW_W-1:0]     mem_wdata,
    output logic [IDX_W-1:0]    cur_idx,
    output logic                tap_drive,
    output logic                half_mode,
    output logic                done,
    output logic                fail
);
    typedef struct packed {
        st_e              st;
        logic             down;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] left;
        logic [1:0]       widx;
        logic             drive;
        logic             done;
        logic             fail;
    } regs_t;

    regs_t          cur_q, nxt_d;
    logic           load_d;
    logic           pass_w;
    logic [IDX_W:0] mid_sum;

    always_comb begin
        nxt_d   = cur_q;
        load_d  = 1'b0;
        pass_w  = (mem_rdata[CHK_HW*HW_W +: HW_W] == pattern_word(2'(CHK_HW)));
        mid_sum = {1'b0, cur_q.left} + {1'b0, cur_q.idx};
        unique case (cur_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    nxt_d.st    = ST_SETTLE;
                    nxt_d.idx   = '0;
                    nxt_d.down  = 1'b0;
                    nxt_d.drive = 1'b1;
                    nxt_d.done  = 1'b0;
                    nxt_d.fail  = 1'b0;
                    load_d      = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle_expired) begin
                    nxt_d.st   = ST_WRITE;
                    nxt_d.widx = '0;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    if (cur_q.widx == 2'd3) nxt_d.st = ST_READ;
                    else                    nxt_d.widx = cur_q.widx + 1'b1;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    if (!cur_q.down) begin
                        if (pass_w) begin
                            nxt_d.left = cur_q.idx;
                            nxt_d.idx  = LAST_IDX;
                            nxt_d.down = 1'b1;
                            nxt_d.st   = ST_SETTLE;
                            load_d     = 1'b1;
                        end else if (cur_q.idx == LAST_IDX) begin
                            nxt_d.fail  = 1'b1;
                            nxt_d.done  = 1'b1;
                            nxt_d.drive = 1'b0;
                            nxt_d.st    = ST_DONE;
                        end else begin
                            nxt_d.idx = cur_q.idx + 1'b1;
                            nxt_d.st  = ST_SETTLE;
                            load_d    = 1'b1;
                        end
                    end else if (pass_w || cur_q.idx == cur_q.left) begin
                        nxt_d.idx  = mid_sum[IDX_W:1];
                        nxt_d.done = 1'b1;
                        nxt_d.st   = ST_DONE;
                    end else begin
                        nxt_d.idx = cur_q.idx - 1'b1;
                        nxt_d.st  = ST_SETTLE;
                        load_d    = 1'b1;
                    end
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign settle_load = load_d;
    assign mem_req     = (cur_q.st == ST_WRITE) || (cur_q.st == ST_READ);
    assign mem_we      = (cur_q.st == ST_WRITE);
    assign mem_addr    = (cur_q.st == ST_WRITE) ? ADDR_W'({cur_q.widx, 1'b0}) : '0;
    assign mem_wdata   = (cur_q.st == ST_WRITE) ? pattern_word(cur_q.widx) : '0;
    assign cur_idx     = cur_q.idx;
    assign tap_drive   = cur_q.drive;
    assign half_mode   = (cur_q.st != ST_IDLE) && (cur_q.st != ST_DONE);
    assign done        = cur_q.done;
    assign fail        = cur_q.fail;

    // cycles spent in the settle state, used only by the check below
    logic [SETTLE_W:0] dwell_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    dwell_q <= '0;
        else if (cur_q.st == ST_SETTLE) dwell_q <= dwell_q + 1'b1;
        else                           dwell_q <= '0;
    end

    // R7: leaving settle happens after exactly settle_cycles+1 cycles
    a_r7_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_SETTLE && nxt_d.st == ST_WRITE) |-> dwell_q == {1'b0, settle_cycles});
    // R8: an unacknowledged request holds all its fields
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R9: a failed search never drives a candidate
    a_r9_fail_idle_tap: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!tap_drive && done));
    // R11: no traffic and no narrow mode once finished
    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && !half_mode));
    // R12: the downward scan stays at or above the left edge
    a_r12_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (half_mode && cur_q.down) |-> (cur_q.idx >= cur_q.left));
    // R1: the index never leaves the table
    a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        cur_idx <= LAST_IDX);
    // R10: a start during a search leaves done low
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (half_mode && start && !(cur_q.st == ST_READ && mem_ack)) |=> half_mode);
endmodule

// File: rtl/tapcal_top.sv
module tapcal_top
    import tapcal_pkg::*;
#(
    parameter int SETTLE_W = 8,
    parameter int ADDR_W   = 4,
    parameter int LANES    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SETTLE_W-1:0]    settle_cycles,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [HW_W-1:0]        mem_wdata,
    input  logic                   mem_ack,
    input  logic [LINE_W-1:0]      mem_rdata,
    output logic [TAP_W*LANES-1:0] tap_lanes,
    output logic                   half_mode,
    output logic                   done,
    output logic                   fail
);
    logic [IDX_W-1:0] cur_idx;
    logic [TAP_W-1:0] code;
    logic             tap_drive, settle_load, settle_expired;

    tapcal_ctrl #(.SETTLE_W(SETTLE_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
        .settle_expired(settle_expired), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .settle_load(settle_load), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_idx(cur_idx),
        .tap_drive(tap_drive), .half_mode(half_mode), .done(done), .fail(fail)
    );

    tapcal_settle #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .load(settle_load), .load_val(settle_cycles),
        .expired(settle_expired)
    );

    tapcal_table u_table (.idx(cur_idx), .code(code));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign tap_lanes[g*TAP_W +: TAP_W] = tap_drive ? code : '0;
    end
endmodule

// File: tb/tapcal_top_test.sv
module tapcal_top_test;
    localparam int SW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, start_main, stray_start, start_in;
    logic [SW-1:0] settle;
    logic          mem_req, mem_we, mem_ack, half_mode, done, fail;
    logic [3:0]    mem_addr;
    logic [15:0]   mem_wdata;
    logic [63:0]   mem_rdata;
    logic [31:0]   tap_lanes;

    assign start_in = start_main | stray_start;

    tapcal_top #(.SETTLE_W(SW), .ADDR_W(4), .LANES(4)) uut (
        .clk(clk), .rst_n(rst_n), .start(start_in), .settle_cycles(settle),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tap_lanes(tap_lanes),
        .half_mode(half_mode), .done(done), .fail(fail)
    );

    int checks = 0, failures = 0;
    logic [7:0] tbl [11] = '{8'h40, 8'h41, 8'h10, 8'h12, 8'h13, 8'h15,
                              8'h1A, 8'h1C, 8'h1F, 8'h2F, 8'h3F};

    // memory model state
    logic [10:0] mask;
    bit          flaky, gap_pending;
    int          lat, waitc, seq, seq_err, gap_err, reads, gcnt, ack_total, stray_at;
    logic [15:0] mem [4];
    bit          seen [11];

    function automatic int lookup(input logic [7:0] c);
        for (int i = 0; i < 11; i++) if (tbl[i] == c) return i;
        return -1;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; mem_rdata = '0; stray_start = 1'b0;
            waitc = 0; gap_pending = 0; gcnt = 0;
        end else begin
            gcnt++;
            if (start_in && !half_mode) begin gap_pending = 1; gcnt = 0; end
            stray_start = 1'b0;
            if (gap_pending && mem_req) begin
                if (gcnt != int'(settle) + 2) gap_err++;
                gap_pending = 0;
            end
            if (mem_ack) begin
                mem_ack = 1'b0; waitc = lat;
            end else if (mem_req) begin
                if (!half_mode) seq_err++;
                if (waitc > 0) waitc--;
                else begin
                    if (mem_we) begin
                        if (seq > 3 || int'(mem_addr) != seq * 2 ||
                            mem_wdata != 16'h00A5 + 16'h0011 * 16'(seq)) seq_err++;
                        mem[mem_addr[2:1]] = mem_wdata;
                        seq++;
                    end else begin
                        int ti;
                        bit ok;
                        if (seq != 4 || mem_addr != 4'd0) seq_err++;
                        seq = 0; reads++;
                        ti = lookup(tap_lanes[7:0]);
                        ok = (ti >= 0) && mask[ti] && !(flaky && seen[ti]);
                        if (ti >= 0) seen[ti] = 1;
                        mem_rdata = {mem[3], ok ? mem[2] : mem[2] ^ 16'h5A5A, mem[1], mem[0]};
                        gap_pending = 1; gcnt = 0;
                    end
                    mem_ack = 1'b1; ack_total++;
                    if (ack_total == stray_at) stray_start = 1'b1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [10:0] m, input bit fl, input int lt, input int st, input int stray);
        int l, r, n, exp_reads;
        bit exp_fail;
        logic [7:0] exp_tap;
        mask = m; flaky = fl; lat = lt; settle = SW'(st); stray_at = stray;
        reads = 0; seq = 0; seq_err = 0; gap_err = 0; ack_total = 0; waitc = lt;
        for (int i = 0; i < 11; i++) seen[i] = 0;
        @(posedge clk); #2 start_main = 1'b1;
        @(posedge clk); #2 start_main = 1'b0;
        n = 0;
        while (n < 6000) begin
            @(negedge clk); n++;
            if (done) break;
        end
        l = -1; r = -1;
        for (int i = 0; i < 11; i++) if (m[i]) begin if (l < 0) l = i; r = i; end
        if (fl) r = l;
        exp_fail  = (m == '0);
        exp_tap   = exp_fail ? 8'h00 : tbl[(l + r) / 2];
        exp_reads = exp_fail ? 11 : (l + 1) + (10 - r + 1);
        chk(done == 1'b1, "R6 done", int'(done), 1);
        chk(fail == exp_fail, exp_fail ? "R9 fail flag" : "R4 R5 no fail", int'(fail), int'(exp_fail));
        chk(tap_lanes == {4{exp_tap}}, exp_fail ? "R9 zero tap" : "R6 R12 final tap", int'(tap_lanes), int'({4{exp_tap}}));
        chk(reads == exp_reads, "R4 R5 R1 candidate count", reads, exp_reads);
        chk(seq_err == 0, "R2 R3 R8 R11 access order", seq_err, 0);
        chk(gap_err == 0, "R7 settle gap", gap_err, 0);
        chk(half_mode == 1'b0, "R11 half mode off", int'(half_mode), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_main = 1'b0; settle = '0;
        mask = '0; flaky = 0; lat = 0; stray_at = 0; seq = 0; reads = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(done == 0 && fail == 0, "R13 flags", int'({done, fail}), 0);
        chk(tap_lanes == '0, "R13 tap", int'(tap_lanes), 0);
        chk(mem_req == 0 && half_mode == 0, "R13 port idle", int'({mem_req, half_mode}), 0);
        // R4 R5 R6: every contiguous passing window
        for (int lo = 0; lo < 11; lo++)
            for (int hi = lo; hi < 11; hi++)
                run(11'(((1 << (hi + 1)) - 1) & ~((1 << lo) - 1)), 0, (lo + hi) % 3, (lo * 3 + hi) % 4, 0);
        // R9: nothing passes
        run(11'b0, 0, 1, 1, 0);
        // R3 R4 R5: sparse passing sets
        run(11'b10000010100, 0, 0, 0, 0);
        run(11'b00100000001, 0, 2, 3, 0);
        // R12: left edge fails on revisit
        run(11'b00000001000, 1, 1, 0, 0);
        run(11'b10000000000, 1, 0, 2, 0);
        // R10: stray start together with the fifth acknowledge
        run(11'b00011110000, 0, 1, 2, 5);
        run(11'b00000000111, 0, 0, 1, 5);
        // R10: restart from the finished state clears fail
        run(11'b0, 0, 0, 0, 0);
        run(11'b00001000000, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule